// File: doc/BRIEF.md
# Reloadable Event Down-Counter Timer Group

A group of timer channels, three by default, in which each channel holds a 16-bit down-counter that moves on events instead of on a prescaled clock. A channel takes its events from one of two places. The first is its own input pin, which is synchronized and watched for a falling edge, a rising edge or either edge. The second is the underflow pulse of the channel before it in the ring, and channel 0 takes the pulse of the last channel. When the counter is zero and an event arrives, the channel reloads from its reload register and puts out a single-cycle underflow pulse. That pulse is the channel's interrupt request and also the event for the next channel. A programmed value n therefore divides the event rate by n+1.

Software reaches the group through a small register port that has three registers per channel: a mode byte, the timer value and a shared run mask. A timer write is routed according to the state of the channel. While the channel is halted, or has been started but has not yet counted an event, the write sets both the counter and the reload register. After the first counted event, the write sets only the reload register, and the counter picks up the new value at its next reload. Reads return the live counter at any time.

Top module: `evt_dcnt_group`

## Requirements
- R1: After reset every counter, reload register, mode byte and run bit is 0, and no underflow pulse is present.
- R2: A running channel in event mode (mode bits [1:0] = 01) decrements its counter by exactly one for each qualifying event.
- R3: With the pin source selected, mode bits [3:2] choose the edge: 00 counts falling edges only, 01 counts rising edges only, 10 counts both, and 11 counts nothing.
- R4: An event that arrives with the counter at 0 loads the reload value and raises that channel's underflow output for exactly one clock cycle, so a value n gives one pulse per n+1 events.
- R5: A timer write while the channel is halted, or after a start but before the first counted event, sets both the counter and the reload register.
- R6: Once an event has been counted since the last start, a timer write leaves the counter unchanged and changes only the value loaded at the next underflow.
- R7: When a timer write and an underflow reload fall in the same cycle, the counter takes the written value.
- R8: With mode bit 6 set, a channel counts the underflow pulses of channel i-1 (channel 0 counts those of the last channel), and the edge field has no effect.
- R9: A channel with its run bit at 0, or with mode bits [1:0] other than 01, does not count.
- R10: A read at address 1 returns the channel's live counter; address 0 returns its mode byte; address 2 returns the run mask, one bit per channel.
- R11: A 0-to-1 change of a run bit re-arms the routing of R5 for that channel, so writes reach the counter again until the next counted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_CH | Asynchronous event pins, one per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 mode, 1 timer, 2 run mask |
| reg_ch_i | input | CHW | Channel select for mode and timer access |
| reg_wdata_i | input | CW | Write data |
| rd_data_o | output | CW | Read data for the selected address and channel |
| irq_o | output | NUM_CH | Underflow pulses, one per channel |

## Verification
The hardest case to reach is a timer write that lands in the same cycle as an underflow reload (R7). The pin path has a fixed latency through the synchronizer and edge detector, so the bench brings the counter to zero and raises the pin. It then places the write strobe exactly two cycles later, which lines the write up with the reload edge. The cascade case, where a first-event flag set by a neighbour's pulse then redirects later writes, comes up in the random phase. That phase mixes pin toggles, re-programmed modes and run masks, and small timer values across chained channels.

// File: rtl/evt_dcnt_pkg.sv
package evt_dcnt_pkg;

  typedef enum logic [1:0] {
    ADDR_MODE = 2'd0,
    ADDR_TMR  = 2'd1,
    ADDR_RUN  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    POL_FALL = 2'b00,
    POL_RISE = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  localparam logic [1:0] OPM_EVENT = 2'b01;

  // mode byte: [7] rsv, [6] neighbour source, [5:4] rsv, [3:2] edge, [1:0] op mode
  typedef struct packed {
    logic       rsv7;
    logic       src_nbr;
    logic [1:0] rsv54;
    pol_e       pol;
    logic [1:0] opm;
  } mode_t;

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/evt_src_sel.sv
module evt_src_sel
  import evt_dcnt_pkg::*;
(
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       nbr_uf_i,
  input  logic       src_nbr_i,
  input  pol_e       pol_i,
  input  logic [1:0] opm_i,
  input  logic       run_i,
  output logic       evt_o
);

  logic pin_evt;
  logic raw_evt;

  always_comb begin
    unique case (pol_i)
      POL_FALL: pin_evt = fall_i;
      POL_RISE: pin_evt = rise_i;
      POL_BOTH: pin_evt = rise_i | fall_i;
      default:  pin_evt = 1'b0;
    endcase
  end

  assign raw_evt = src_nbr_i ? nbr_uf_i : pin_evt;
  assign evt_o   = raw_evt & run_i & (opm_i == OPM_EVENT);

endmodule

// File: rtl/evt_dcnt_chan.sv
module evt_dcnt_chan #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic          run_i,
  input  logic          tmr_we_i,
  input  logic [CW-1:0] tmr_wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          first_o,
  output logic          uf_o
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, reload_q;
  logic          run_d_q, first_q, uf_q;
  logic          run_rise, at_zero, reload_now, wr_to_cnt;

  assign run_rise   = run_i & ~run_d_q;
  assign at_zero    = (cnt_q == '0);
  assign reload_now = evt_i & at_zero;
  // write reaches counter when halted, before first event, or on a reload edge
  assign wr_to_cnt  = tmr_we_i & (~run_i | ~first_q | run_rise | reload_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
      run_d_q  <= 1'b0;
      first_q  <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      run_d_q <= run_i;
      uf_q    <= reload_now;
      if (evt_i)         first_q <= 1'b1;
      else if (run_rise) first_q <= 1'b0;
      if (tmr_we_i) reload_q <= tmr_wdata_i;
      if (wr_to_cnt)       cnt_q <= tmr_wdata_i;
      else if (reload_now) cnt_q <= reload_q;
      else if (evt_i)      cnt_q <= cnt_q - ONE;
    end
  end

  assign cnt_o   = cnt_q;
  assign first_o = first_q;
  assign uf_o    = uf_q;

endmodule

// File: rtl/evt_dcnt_group.sv
module evt_dcnt_group
  import evt_dcnt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CW     = 16,
  parameter int SYNC   = 2,
  parameter int CHW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [CHW-1:0]    reg_ch_i,
  input  logic [CW-1:0]     reg_wdata_i,
  output logic [CW-1:0]     rd_data_o,
  output logic [NUM_CH-1:0] irq_o
);

  localparam logic [CHW-1:0] LAST_CH = CHW'(NUM_CH - 1);

  mode_t [NUM_CH-1:0]         mode_q;
  logic  [NUM_CH-1:0]         run_q;
  logic  [NUM_CH-1:0][CW-1:0] cnt;
  logic  [NUM_CH-1:0]         evt, first_seen, uf, tmr_we;
  logic  [NUM_CH-1:0]         rise, fall;
  logic                       ch_ok;
  reg_addr_e                  addr;

  assign addr  = reg_addr_e'(reg_addr_i);
  assign ch_ok = (reg_ch_i <= LAST_CH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= '0;
    end else if (reg_we_i) begin
      if (addr == ADDR_RUN) run_q <= reg_wdata_i[NUM_CH-1:0];
      if (addr == ADDR_MODE && ch_ok) mode_q[reg_ch_i] <= mode_t'(reg_wdata_i[7:0]);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int NBR = (g == 0) ? NUM_CH - 1 : g - 1;

    assign tmr_we[g] = reg_we_i && (addr == ADDR_TMR) && (reg_ch_i == CHW'(g));

    evt_sync_edge #(.STAGES(SYNC)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (pin_i[g]),
      .rise_o(rise[g]),
      .fall_o(fall[g])
    );

    evt_src_sel u_sel (
      .rise_i   (rise[g]),
      .fall_i   (fall[g]),
      .nbr_uf_i (uf[NBR]),
      .src_nbr_i(mode_q[g].src_nbr),
      .pol_i    (mode_q[g].pol),
      .opm_i    (mode_q[g].opm),
      .run_i    (run_q[g]),
      .evt_o    (evt[g])
    );

    evt_dcnt_chan #(.CW(CW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[g]),
      .run_i      (run_q[g]),
      .tmr_we_i   (tmr_we[g]),
      .tmr_wdata_i(reg_wdata_i),
      .cnt_o      (cnt[g]),
      .first_o    (first_seen[g]),
      .uf_o       (uf[g])
    );
  end

  assign irq_o = uf;

  always_comb begin
    rd_data_o = '0;
    unique case (addr)
      ADDR_MODE: if (ch_ok) rd_data_o = CW'(mode_q[reg_ch_i]);
      ADDR_TMR:  if (ch_ok) rd_data_o = cnt[reg_ch_i];
      ADDR_RUN:  rd_data_o = CW'(run_q);
      default:   rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/evt_dcnt_group_chk.sv
module evt_dcnt_group_chk #(
  parameter int NUM_CH = 3,
  parameter int CW     = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_CH-1:0][CW-1:0] cnt_i,
  input logic [NUM_CH-1:0]         evt_i,
  input logic [NUM_CH-1:0]         first_i,
  input logic [NUM_CH-1:0]         uf_i,
  input logic [NUM_CH-1:0]         we_i,
  input logic [NUM_CH-1:0]         run_i,
  input logic [NUM_CH-1:0][7:0]    mode_i,
  input logic [CW-1:0]             wdata_i
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_a
    AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[g] && !we_i[g] && cnt_i[g] != '0) |=> (cnt_i[g] == $past(cnt_i[g]) - ONE)); // R2
    AST_RSVD_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i[g][6] && mode_i[g][3:2] == 2'b11) |-> !evt_i[g]); // R3
    AST_UF_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uf_i[g] |-> ($past(cnt_i[g]) == '0 && $past(evt_i[g]))); // R4
    AST_LATE_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (first_i[g] && run_i[g] && $past(run_i[g]) && we_i[g] && !evt_i[g]) |=> $stable(cnt_i[g])); // R6
    AST_WR_WINS_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[g] && evt_i[g] && cnt_i[g] == '0) |=> (cnt_i[g] == $past(wdata_i))); // R7
    AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i[g] && !we_i[g]) |=> $stable(cnt_i[g])); // R9
  end

endmodule

bind evt_dcnt_group evt_dcnt_group_chk #(.NUM_CH(NUM_CH), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cnt_i  (cnt),
  .evt_i  (evt),
  .first_i(first_seen),
  .uf_i   (uf),
  .we_i   (tmr_we),
  .run_i  (run_q),
  .mode_i (mode_q),
  .wdata_i(reg_wdata_i)
);

// File: tb/evt_dcnt_group_bench.sv
module evt_dcnt_group_bench;

  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] pin = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [1:0]    ch = 2'd0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [NC-1:0] irq;

  int total = 0;
  int bad = 0;

  logic [15:0] m_cnt [NC];
  logic [15:0] m_rel [NC];
  logic [7:0]  m_mode[NC];
  logic        m_first[NC];
  logic [NC-1:0] m_run;
  int          m_uf [NC];
  int          irq_seen[NC];

  always #10 clk = ~clk;

  evt_dcnt_group u_evt_dcnt_group (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pin_i      (pin),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_ch_i   (ch),
    .reg_wdata_i(wdata),
    .rd_data_o  (rdata),
    .irq_o      (irq)
  );

  always @(negedge clk)
    if (rst_n)
      for (int c = 0; c < NC; c++) irq_seen[c] += int'(irq[c]);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input int c, output logic [15:0] v);
    @(negedge clk);
    addr = a; ch = 2'(c);
    #1 v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input int c, input logic [15:0] v);
    @(negedge clk);
    we = 1'b1; addr = a; ch = 2'(c); wdata = v;
    @(negedge clk);
    we = 1'b0;
    if (a == 2'd1) begin
      m_rel[c] = v;
      if (!m_run[c] || !m_first[c]) m_cnt[c] = v;
    end else if (a == 2'd0) begin
      m_mode[c] = v[7:0];
    end else if (a == 2'd2) begin
      for (int k = 0; k < NC; k++)
        if (v[k] && !m_run[k]) m_first[k] = 1'b0;
      m_run = v[NC-1:0];
    end
  endtask

  function automatic bit pin_qual(int c, bit rising);
    if (m_mode[c][6]) return 1'b0;
    case (m_mode[c][3:2])
      2'b00:   return !rising;
      2'b01:   return rising;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic evt_apply(input int c, output bit uf);
    uf = 1'b0;
    if (m_run[c] && m_mode[c][1:0] == 2'b01) begin
      m_first[c] = 1'b1;
      if (m_cnt[c] == 16'h0) begin
        m_cnt[c] = m_rel[c];
        m_uf[c]++;
        uf = 1'b1;
      end else begin
        m_cnt[c] = m_cnt[c] - 16'h1;
      end
    end
  endtask

  task automatic cascade(input int c0, input bit uf0);
    bit uf;
    int cur;
    uf = uf0; cur = c0;
    for (int h = 0; h < NC && uf; h++) begin
      cur = (cur + 1) % NC;
      if (m_mode[cur][6]) evt_apply(cur, uf);
      else uf = 1'b0;
    end
  endtask

  task automatic pin_set(input int c, input bit v);
    bit old, uf;
    @(negedge clk);
    old = pin[c];
    pin[c] = v;
    if (old != v && pin_qual(c, v)) begin
      evt_apply(c, uf);
      cascade(c, uf);
    end
    repeat (7) @(negedge clk);
  endtask

  task automatic chk_cnt(string req, int c);
    logic [15:0] v;
    rd(2'd1, c, v);
    check(req, {16'h0, v}, {16'h0, m_cnt[c]});
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < NC; c++) begin
      chk_cnt(req, c);
      check({req, " irq"}, irq_seen[c], m_uf[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int uf0;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < NC; c++) begin
      m_cnt[c] = '0; m_rel[c] = '0; m_mode[c] = '0; m_first[c] = 1'b0;
      m_uf[c] = 0; irq_seen[c] = 0;
    end
    m_run = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int c = 0; c < NC; c++) begin
      rd(2'd1, c, v); check("R1 cnt", {16'h0, v}, 32'h0);
      rd(2'd0, c, v); check("R10 R1 mode", {16'h0, v}, 32'h0);
    end
    rd(2'd2, 0, v); check("R1 run", {16'h0, v}, 32'h0);
    check("R1 irq", {29'h0, irq}, 32'h0);

    // R5: halted write reaches counter; R10 mode readback
    wr(2'd0, 0, 16'h0005);
    rd(2'd0, 0, v); check("R10 mode", {16'h0, v}, 32'h5);
    wr(2'd1, 0, 16'd3);
    rd(2'd1, 0, v); check("R5 halted", {16'h0, v}, 32'd3);
    wr(2'd2, 0, 16'h1);
    rd(2'd2, 0, v); check("R10 run", {16'h0, v}, 32'h1);
    pin_set(0, 1);
    rd(2'd1, 0, v); check("R2 first dec", {16'h0, v}, 32'd2);
    wr(2'd1, 0, 16'd10);
    rd(2'd1, 0, v); check("R6 reload only", {16'h0, v}, 32'd2);
    pin_set(0, 0);
    rd(2'd1, 0, v); check("R3 fall ignored on rise", {16'h0, v}, 32'd2);
    pin_set(0, 1); pin_set(0, 0); pin_set(0, 1); pin_set(0, 0);
    rd(2'd1, 0, v); check("R2 at zero", {16'h0, v}, 32'd0);
    pin_set(0, 1);
    rd(2'd1, 0, v); check("R6 R4 reload new", {16'h0, v}, 32'd10);
    check("R4 one pulse", irq_seen[0], 1);

    // R11: restart re-arms write routing
    wr(2'd2, 0, 16'h0); wr(2'd2, 0, 16'h1);
    wr(2'd1, 0, 16'd7);
    rd(2'd1, 0, v); check("R11 R5 after restart", {16'h0, v}, 32'd7);

    // R3: edge field variants
    wr(2'd0, 0, 16'h0001);
    pin_set(0, 0); chk_cnt("R3 fall", 0);
    pin_set(0, 1); chk_cnt("R3 fall only", 0);
    wr(2'd0, 0, 16'h0009);
    pin_set(0, 0); pin_set(0, 1); chk_cnt("R3 both", 0);
    wr(2'd0, 0, 16'h000d);
    pin_set(0, 0); pin_set(0, 1);
    rd(2'd1, 0, v); check("R3 reserved", {16'h0, v}, {16'h0, m_cnt[0]});

    // R9: halted and wrong op mode
    wr(2'd0, 0, 16'h0005);
    wr(2'd2, 0, 16'h0);
    pin_set(0, 0); pin_set(0, 1);
    rd(2'd1, 0, v); check("R9 halted", {16'h0, v}, 32'd4);
    wr(2'd2, 0, 16'h1);
    wr(2'd0, 0, 16'h0004);
    pin_set(0, 0); pin_set(0, 1);
    rd(2'd1, 0, v); check("R9 mode off", {16'h0, v}, 32'd4);

    // R8: neighbour source, edge field ignored
    wr(2'd0, 0, 16'h0005);
    wr(2'd0, 1, 16'h004d);
    wr(2'd1, 0, 16'd1);
    wr(2'd1, 1, 16'd5);
    wr(2'd2, 0, 16'h3);
    pin_set(0, 0); pin_set(0, 1); pin_set(0, 0); pin_set(0, 1);
    rd(2'd1, 1, v); check("R8 ch1 from ch0", {16'h0, v}, 32'd4);
    wr(2'd0, 2, 16'h0005);
    wr(2'd0, 0, 16'h0041);
    wr(2'd1, 2, 16'd0);
    wr(2'd2, 0, 16'h7);
    uf0 = int'(m_cnt[0]);
    pin_set(2, 1);
    rd(2'd1, 0, v); check("R8 ch0 from ch2", {16'h0, v}, 32'(uf0 - 1));
    chk_all("R8 chain");

    // R7: write coincides with reload
    wr(2'd0, 1, 16'h0000);
    wr(2'd0, 0, 16'h0005);
    wr(2'd2, 0, 16'h0);
    wr(2'd1, 0, 16'd1);
    wr(2'd2, 0, 16'h1);
    pin_set(0, 0);
    pin_set(0, 1);
    pin_set(0, 0);
    chk_cnt("R7 setup", 0);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd1; ch = 2'd0; wdata = 16'h1234;
    @(negedge clk); we = 1'b0;
    m_cnt[0] = 16'h1234; m_rel[0] = 16'h1234; m_uf[0]++;
    repeat (6) @(negedge clk);
    rd(2'd1, 0, v); check("R7 write wins", {16'h0, v}, 32'h1234);
    check("R7 irq", irq_seen[0], m_uf[0]);
    pin_set(0, 0); pin_set(0, 1);
    chk_cnt("R7 next dec", 0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op, c;
      logic [15:0] d;
      op = $urandom_range(0, 99);
      c  = $urandom_range(0, NC - 1);
      if (op < 60) begin
        pin_set(c, ~pin[c]);
      end else if (op < 75) begin
        wr(2'd1, c, 16'($urandom_range(0, 5)));
      end else if (op < 88) begin
        d = '0;
        d[1:0] = ($urandom_range(0, 3) == 0) ? 2'b00 : 2'b01;
        d[3:2] = 2'($urandom_range(0, 3));
        d[6]   = (c == 0) ? 1'b0 : 1'($urandom_range(0, 1));
        wr(2'd0, c, d);
      end else begin
        wr(2'd2, 0, 16'($urandom_range(0, 7)));
      end
      chk_all("R2 R4 R6 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule